// File: doc/BRIEF.md
# Programmable Signed-Digit FIR Filter

This block is a direct-form FIR filter for sample streams that arrive as fast as one per clock. It contains no general multipliers. Each tap coefficient is stored as a vector of signed digits (0, +1 or −1 at each power of two). For every nonzero digit, the delayed sample of that tap is shifted to the digit's weight and then added, or added after inversion. Every shifted term from every tap feeds one shared carry-save reduction tree. The tree is cut into pipeline stages and ends in a single carry-propagate adder, so the longest path grows only with the logarithm of the term count and not with the number of taps.

Coefficients are written at run time, one tap per write. A write goes into a staging bank and is copied into the working bank when the next sample is accepted, so a sample never sees a half-updated coefficient set. A write whose digit vector has two nonzero digits next to each other raises a one-cycle error pulse. The output is the full-precision sum, with no rounding.

Top module: `csd_fir_filter`

## Requirements
- R1: Each accepted sample x(n) (in_sample, signed two's complement, 10 bits) produces out_sample = Σ h(k)·x(n−k) over the 18 taps k = 0..17. x(n−k) is the sample accepted k acceptances earlier, and it is zero if fewer samples have been accepted since reset.
- R2: A coefficient has 10 digits. Digit d sits in coef_digits[2d+1:2d] and has weight 2^d. Code 2'b01 means +1, code 2'b11 means −1 and code 2'b00 means 0. h equals the weighted digit sum.
- R3: Digit code 2'b10 contributes zero to the coefficient value.
- R4: When in_valid is high in cycle t, out_valid is high for one cycle in cycle t+4 and carries that sample's result. Samples may arrive back to back. out_valid is never high without such an input.
- R5: out_sample is the exact 25-bit two's-complement sum (10+10+5 bits), without rounding, saturation or wrap, for any sample values and any digit vectors.
- R6: coef_we with coef_tap and coef_digits stages a coefficient. It is used from the first sample accepted in a later cycle. A write in the same cycle as in_valid does not affect that sample.
- R7: A write with coef_tap of 18 or more changes no coefficient.
- R8: coef_err is high for exactly the cycle after a write whose digit vector has two adjacent nonzero digits (codes 01 or 11). Code 10 counts as zero for this rule. The coefficient is still stored and used.
- R9: While rst_n is low, out_valid, out_sample and coef_err are 0, and all coefficients and delayed samples are cleared. The release of rst_n takes effect two clock edges later.
- R10: out_sample holds its value in every cycle in which out_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Sample strobe; also commits staged coefficients |
| in_sample | input | 10 | Signed input sample |
| coef_we | input | 1 | Coefficient write strobe |
| coef_tap | input | 5 | Tap index of the write |
| coef_digits | input | 20 | Signed-digit vector, 2 bits per digit |
| coef_err | output | 1 | Adjacent-nonzero-digit error pulse |
| out_valid | output | 1 | Result strobe |
| out_sample | output | 25 | Full-precision signed result |

## Verification
An impulse tested against a coefficient set with mixed signs reads each tap's decoded value back in order. This shows whether digit weights, signs and tap order are correct. A table of mixed-sign samples streamed back to back checks the convolution, the delay-line history and the pipeline's handling of consecutive samples together. Runs of the largest positive and negative samples against all-positive and all-negative maximal coefficients push the sum close to the 25-bit limit, which exposes any dropped carry or lost subtraction carry-in. Directed writes then separate the remaining cases: the unused code, an adjacency violation, an out-of-range tap, and a write landing in the same cycle as a sample.

// File: rtl/csd_fir_pkg.sv
package csd_fir_pkg;

  typedef enum logic [1:0] {
    DIG_ZERO  = 2'b00,
    DIG_PLUS  = 2'b01,
    DIG_BAD   = 2'b10,
    DIG_MINUS = 2'b11
  } csd_dig_e;

  // rows left after lv levels of 3:2 compression
  function automatic int csa_rows_after(int n, int lv);
    int r;
    r = n;
    for (int i = 0; i < lv; i++) r = 2 * (r / 3) + (r % 3);
    return r;
  endfunction

  // levels of 3:2 compression needed to reach two rows
  function automatic int csa_depth(int n);
    int r;
    int c;
    r = n;
    c = 0;
    while (r > 2) begin
      r = 2 * (r / 3) + (r % 3);
      c++;
    end
    return c;
  endfunction

  function automatic logic dig_nonzero(logic [1:0] code);
    return (code == DIG_PLUS) || (code == DIG_MINUS);
  endfunction

endpackage

// File: rtl/csd_tap_line.sv
module csd_tap_line #(
  parameter int DATA_W = 10,
  parameter int TAPS   = 18
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           shift_en,
  input  logic [DATA_W-1:0]              din,
  output logic [TAPS-1:0][DATA_W-1:0]    taps_o
);

  logic [TAPS-1:0][DATA_W-1:0] line_q;
  logic [TAPS-1:0][DATA_W-1:0] line_d;

  always_comb begin
    line_d = line_q;
    if (shift_en) begin
      line_d[0] = din;
      for (int k = 1; k < TAPS; k++) line_d[k] = line_q[k-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_q <= '0;
    else        line_q <= line_d;
  end

  assign taps_o = line_q;

  // R1: each accepted sample moves one tap deeper
  a_r1_shift: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> line_q[1] == $past(line_q[0]));

endmodule

// File: rtl/csd_coef_bank.sv
module csd_coef_bank import csd_fir_pkg::*; #(
  parameter int TAPS   = 18,
  parameter int DIGITS = 10,
  parameter int IDX_W  = 5
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en_i,
  input  logic [IDX_W-1:0]                wr_idx_i,
  input  logic [2*DIGITS-1:0]             wr_dig_i,
  input  logic                            commit_i,
  output logic [TAPS-1:0][2*DIGITS-1:0]   active_o,
  output logic                            err_o
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(TAPS - 1);

  logic [TAPS-1:0][2*DIGITS-1:0] shadow_q, shadow_d;
  logic [TAPS-1:0][2*DIGITS-1:0] active_q, active_d;
  logic                          err_q, err_d;
  logic [DIGITS-1:0]             nz;
  logic                          adj_viol;
  logic                          idx_ok;

  always_comb begin
    for (int d = 0; d < DIGITS; d++) nz[d] = dig_nonzero(wr_dig_i[2*d +: 2]);
  end

  assign adj_viol = |(nz[DIGITS-1:1] & nz[DIGITS-2:0]);
  assign idx_ok   = (wr_idx_i <= LAST_IDX);

  always_comb begin
    shadow_d = shadow_q;
    if (wr_en_i && idx_ok) shadow_d[wr_idx_i] = wr_dig_i;
    active_d = active_q;
    if (commit_i) active_d = shadow_q;
    err_d = wr_en_i & adj_viol;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
      active_q <= '0;
      err_q    <= 1'b0;
    end else begin
      shadow_q <= shadow_d;
      active_q <= active_d;
      err_q    <= err_d;
    end
  end

  assign active_o = active_q;
  assign err_o    = err_q;

  // R6: working bank changes only at a sample boundary
  a_r6_hold_active: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_i |=> $stable(active_q));

  // R7: out-of-range index leaves the staging bank untouched
  a_r7_bad_index: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !idx_ok) |=> $stable(shadow_q));

  // R8: the error pulse always follows a write
  a_r8_err_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> $past(wr_en_i));

endmodule

// File: rtl/csd_pp_gen.sv
module csd_pp_gen import csd_fir_pkg::*; #(
  parameter  int DATA_W = 10,
  parameter  int TAPS   = 18,
  parameter  int DIGITS = 10,
  parameter  int ACC_W  = 25,
  localparam int N_PP   = TAPS * DIGITS + 1
) (
  input  logic [TAPS-1:0][DATA_W-1:0]    taps_i,
  input  logic [TAPS-1:0][2*DIGITS-1:0]  coef_i,
  output logic [ACC_W-1:0]               rows_o [N_PP]
);

  localparam int N_TERM = TAPS * DIGITS;

  logic [N_TERM-1:0] neg_bits;
  logic [ACC_W-1:0]  neg_cnt;

  for (genvar k = 0; k < TAPS; k++) begin : g_tap
    logic [ACC_W-1:0] sx;
    assign sx = {{(ACC_W-DATA_W){taps_i[k][DATA_W-1]}}, taps_i[k]};
    for (genvar d = 0; d < DIGITS; d++) begin : g_dig
      logic [1:0]       code;
      logic [ACC_W-1:0] sh;
      assign code = coef_i[k][2*d +: 2];
      assign sh   = sx << d;
      assign neg_bits[k*DIGITS+d] = (code == DIG_MINUS);
      // minus digit: inverted term, its +1 arrives through the count row
      assign rows_o[k*DIGITS+d] = (code == DIG_PLUS)  ? sh  :
                                  (code == DIG_MINUS) ? ~sh : '0;
    end
  end

  always_comb begin
    neg_cnt = '0;
    for (int i = 0; i < N_TERM; i++) neg_cnt = neg_cnt + ACC_W'(neg_bits[i]);
  end

  assign rows_o[N_PP-1] = neg_cnt;

endmodule

// File: rtl/csa_reduce.sv
module csa_reduce import csd_fir_pkg::*; #(
  parameter int W      = 25,
  parameter int N_IN   = 9,
  parameter int LEVELS = 2,
  parameter int N_OUT  = csa_rows_after(N_IN, LEVELS)
) (
  input  logic [W-1:0] rows_i [N_IN],
  output logic [W-1:0] rows_o [N_OUT]
);

  for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
    localparam int NI = csa_rows_after(N_IN, l);
    localparam int NO = csa_rows_after(N_IN, l + 1);
    localparam int NG = NI / 3;
    logic [W-1:0] src [NI];
    logic [W-1:0] dst [NO];

    if (l == 0) begin : g_first
      assign src = rows_i;
    end else begin : g_next
      assign src = g_lvl[l-1].dst;
    end

    for (genvar g = 0; g < NG; g++) begin : g_fa
      logic [W-1:0] a, b, c;
      assign a = src[3*g];
      assign b = src[3*g+1];
      assign c = src[3*g+2];
      assign dst[2*g]   = a ^ b ^ c;
      assign dst[2*g+1] = ((a & b) | (a & c) | (b & c)) << 1;
    end

    for (genvar r = 0; r < NI - 3*NG; r++) begin : g_pass
      assign dst[2*NG+r] = src[3*NG+r];
    end
  end

  assign rows_o = g_lvl[LEVELS-1].dst;

endmodule

// File: rtl/csd_fir_filter.sv
module csd_fir_filter import csd_fir_pkg::*; #(
  parameter  int DATA_W = 10,
  parameter  int TAPS   = 18,
  parameter  int DIGITS = 10,
  localparam int IDX_W  = (TAPS > 1) ? $clog2(TAPS) : 1,
  localparam int ACC_W  = DATA_W + DIGITS + $clog2(TAPS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [DATA_W-1:0]    in_sample,
  input  logic                 coef_we,
  input  logic [IDX_W-1:0]     coef_tap,
  input  logic [2*DIGITS-1:0]  coef_digits,
  output logic                 coef_err,
  output logic                 out_valid,
  output logic [ACC_W-1:0]     out_sample
);

  localparam int N_PP  = TAPS * DIGITS + 1;
  localparam int L_TOT = csa_depth(N_PP);
  localparam int L_A   = (L_TOT + 2) / 3;
  localparam int L_B   = L_A;
  localparam int L_C   = L_TOT - L_A - L_B;
  localparam int N_A   = csa_rows_after(N_PP, L_A);
  localparam int N_B   = csa_rows_after(N_A, L_B);

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  // stage 0: delay line and working coefficient bank
  logic [TAPS-1:0][DATA_W-1:0]   taps;
  logic [TAPS-1:0][2*DIGITS-1:0] coefs;

  csd_tap_line #(.DATA_W(DATA_W), .TAPS(TAPS)) u_line (
    .clk(clk), .rst_n(rst_i_n), .shift_en(in_valid), .din(in_sample), .taps_o(taps)
  );

  csd_coef_bank #(.TAPS(TAPS), .DIGITS(DIGITS), .IDX_W(IDX_W)) u_bank (
    .clk(clk), .rst_n(rst_i_n), .wr_en_i(coef_we), .wr_idx_i(coef_tap),
    .wr_dig_i(coef_digits), .commit_i(in_valid), .active_o(coefs), .err_o(coef_err)
  );

  logic [ACC_W-1:0] pp_rows [N_PP];

  csd_pp_gen #(.DATA_W(DATA_W), .TAPS(TAPS), .DIGITS(DIGITS), .ACC_W(ACC_W)) u_pp (
    .taps_i(taps), .coef_i(coefs), .rows_o(pp_rows)
  );

  // valid pipeline
  logic [2:0] vld_q, vld_d;
  logic       out_valid_q, out_valid_d;

  always_comb begin
    vld_d       = {vld_q[1:0], in_valid};
    out_valid_d = vld_q[2];
  end

  // reduction stages
  logic [ACC_W-1:0] red_a [N_A];
  logic [ACC_W-1:0] stg_a_q [N_A];
  logic [ACC_W-1:0] stg_a_d [N_A];
  logic [ACC_W-1:0] red_b [N_B];
  logic [ACC_W-1:0] stg_b_q [N_B];
  logic [ACC_W-1:0] stg_b_d [N_B];
  logic [ACC_W-1:0] red_c [2];
  logic [ACC_W-1:0] sum_q, sum_d;

  csa_reduce #(.W(ACC_W), .N_IN(N_PP), .LEVELS(L_A), .N_OUT(N_A)) u_red_a (
    .rows_i(pp_rows), .rows_o(red_a)
  );
  csa_reduce #(.W(ACC_W), .N_IN(N_A), .LEVELS(L_B), .N_OUT(N_B)) u_red_b (
    .rows_i(stg_a_q), .rows_o(red_b)
  );
  csa_reduce #(.W(ACC_W), .N_IN(N_B), .LEVELS(L_C), .N_OUT(2)) u_red_c (
    .rows_i(stg_b_q), .rows_o(red_c)
  );

  always_comb begin
    if (vld_q[0]) stg_a_d = red_a;
    else          stg_a_d = stg_a_q;
    if (vld_q[1]) stg_b_d = red_b;
    else          stg_b_d = stg_b_q;
    if (vld_q[2]) sum_d = red_c[0] + red_c[1];
    else          sum_d = sum_q;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      vld_q       <= '0;
      out_valid_q <= 1'b0;
      stg_a_q     <= '{default: '0};
      stg_b_q     <= '{default: '0};
      sum_q       <= '0;
    end else begin
      vld_q       <= vld_d;
      out_valid_q <= out_valid_d;
      stg_a_q     <= stg_a_d;
      stg_b_q     <= stg_b_d;
      sum_q       <= sum_d;
    end
  end

  assign out_valid  = out_valid_q;
  assign out_sample = sum_q;

  // R4: every result traces back to a sample four cycles earlier
  a_r4_origin: assert property (@(posedge clk) disable iff (!rst_i_n)
    out_valid |-> $past(in_valid, 4));

  // R10: the result register only moves together with out_valid
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_i_n)
    !out_valid |-> $stable(out_sample));

endmodule

// File: tb/csd_fir_filter_test.sv
module csd_fir_filter_test;

  localparam int TAPS   = 18;
  localparam int DIGITS = 10;
  localparam int CW     = 2 * DIGITS;
  localparam int NVEC   = 24;

  localparam int VEC_X [NVEC] = '{3, -7, 100, 511, -512, 0, 1, -1, 250, -250, 17, -300,
                                  42, 0, 0, 511, 511, -512, -512, 5, -5, 123, -77, 9};
  localparam int VEC_H [TAPS] = '{1, -3, 7, 12, -25, 40, -64, 100, 171,
                                  171, 100, -64, 40, -25, 12, 7, -3, 1};

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid;
  logic [9:0]    in_sample;
  logic          coef_we;
  logic [4:0]    coef_tap;
  logic [CW-1:0] coef_digits;
  logic          coef_err;
  logic          out_valid;
  logic [24:0]   out_sample;

  always #4 clk = ~clk;

  csd_fir_filter uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
    .coef_we(coef_we), .coef_tap(coef_tap), .coef_digits(coef_digits),
    .coef_err(coef_err), .out_valid(out_valid), .out_sample(out_sample)
  );

  int    total = 0;
  int    bad   = 0;
  int    sh_m   [TAPS];
  int    act_m  [TAPS];
  int    hist_m [TAPS];
  int    exp_q  [$];
  string cur_req = "R9";

  task automatic check(string req, int act, int exp, string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int csd_decode(logic [CW-1:0] v);
    int acc = 0;
    for (int d = 0; d < DIGITS; d++) begin
      if (v[2*d +: 2] == 2'b01)      acc += (1 << d);
      else if (v[2*d +: 2] == 2'b11) acc -= (1 << d);
    end
    return acc;
  endfunction

  function automatic logic [CW-1:0] csd_encode(int n);
    logic [CW-1:0] v = '0;
    int m = n;
    for (int d = 0; d < DIGITS; d++) begin
      if (m % 2 != 0) begin
        if ((m & 3) == 1) begin v[2*d +: 2] = 2'b01; m = m - 1; end
        else              begin v[2*d +: 2] = 2'b11; m = m + 1; end
      end
      m = m >>> 1;
    end
    return v;
  endfunction

  function automatic int model_step(int x);
    int e = 0;
    for (int k = 0; k < TAPS; k++) act_m[k] = sh_m[k];
    for (int k = TAPS - 1; k > 0; k--) hist_m[k] = hist_m[k-1];
    hist_m[0] = x;
    for (int k = 0; k < TAPS; k++) e += act_m[k] * hist_m[k];
    return e;
  endfunction

  // result monitor: every out_valid is matched against the model queue
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (exp_q.size() == 0) check(cur_req, 1, 0, "unexpected out_valid");
      else begin
        int e;
        e = exp_q.pop_front();
        check(cur_req, int'($signed(out_sample)), e, "out_sample");
      end
    end
  end

  task automatic put_sample(int x);
    in_valid  = 1'b1;
    in_sample = x[9:0];
    exp_q.push_back(model_step(x));
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic put_sample_wr(int x, int idx, logic [CW-1:0] dig);
    in_valid    = 1'b1;
    in_sample   = x[9:0];
    coef_we     = 1'b1;
    coef_tap    = idx[4:0];
    coef_digits = dig;
    exp_q.push_back(model_step(x));
    if (idx < TAPS) sh_m[idx] = csd_decode(dig);
    @(negedge clk);
    in_valid = 1'b0;
    coef_we  = 1'b0;
  endtask

  task automatic wr_coef(int idx, logic [CW-1:0] dig, output logic e1, output logic e2);
    coef_we     = 1'b1;
    coef_tap    = idx[4:0];
    coef_digits = dig;
    if (idx < TAPS) sh_m[idx] = csd_decode(dig);
    @(negedge clk);
    e1 = coef_err;
    coef_we = 1'b0;
    @(negedge clk);
    e2 = coef_err;
  endtask

  task automatic impulse(int a);
    put_sample(a);
    for (int i = 0; i < TAPS - 1; i++) put_sample(0);
  endtask

  task automatic flush();
    repeat (6) @(negedge clk);
    check(cur_req, exp_q.size(), 0, "results outstanding");
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R4 watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic e1, e2;
    int   held;
    rst_n = 1'b0; in_valid = 1'b0; in_sample = '0;
    coef_we = 1'b0; coef_tap = '0; coef_digits = '0;
    for (int k = 0; k < TAPS; k++) begin sh_m[k] = 0; act_m[k] = 0; hist_m[k] = 0; end

    repeat (3) @(negedge clk);
    check("R9", out_valid, 0, "out_valid in reset");
    check("R9", int'(out_sample), 0, "out_sample in reset");
    check("R9", coef_err, 0, "coef_err in reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R9", out_valid, 0, "out_valid after release");
    // R9: cleared coefficients give a zero result
    cur_req = "R9";
    put_sample(200);
    put_sample(-3);
    flush();

    // R4: exact latency of a lone sample
    wr_coef(0, csd_encode(1), e1, e2);
    cur_req = "R4";
    in_valid = 1'b1; in_sample = 10'd5;
    exp_q.push_back(model_step(5));
    @(negedge clk); in_valid = 1'b0;
    check("R4", out_valid, 0, "out_valid t+1");
    @(negedge clk); check("R4", out_valid, 0, "out_valid t+2");
    @(negedge clk); check("R4", out_valid, 0, "out_valid t+3");
    @(negedge clk); check("R4", out_valid, 1, "out_valid t+4");
    @(negedge clk); check("R4", out_valid, 0, "out_valid t+5");
    flush();

    // R2: impulse reads back each signed-digit coefficient
    for (int k = 0; k < TAPS; k++) wr_coef(k, csd_encode(VEC_H[k]), e1, e2);
    cur_req = "R2";
    impulse(1);
    flush();

    // R1: vector table streamed back to back
    cur_req = "R1";
    for (int i = 0; i < NVEC; i++) put_sample(VEC_X[i]);
    flush();

    // R5: extreme sums
    for (int k = 0; k < TAPS; k++) wr_coef(k, csd_encode(682), e1, e2);
    cur_req = "R5";
    for (int i = 0; i < TAPS; i++) put_sample(511);
    for (int i = 0; i < TAPS; i++) put_sample(-512);
    flush();
    for (int k = 0; k < TAPS; k++) wr_coef(k, csd_encode(-682), e1, e2);
    for (int i = 0; i < TAPS; i++) put_sample(-512);
    flush();

    // R3 and R8: unused code and adjacency rule
    for (int k = 0; k < TAPS; k++) wr_coef(k, '0, e1, e2);
    wr_coef(0, 20'b00_00_00_00_00_00_00_01_10_01, e1, e2);
    check("R3", e1, 0, "coef_err with code 10 beside nonzero");
    check("R3", csd_decode(20'b00_00_00_00_00_00_00_01_10_01), 5, "model value");
    wr_coef(1, 20'b00_00_00_00_00_00_00_00_01_01, e1, e2);
    check("R8", e1, 1, "coef_err after adjacent digits");
    check("R8", e2, 0, "coef_err one cycle only");
    wr_coef(2, 20'b00_00_00_00_00_00_00_11_11_00, e1, e2);
    check("R8", e1, 1, "coef_err after adjacent minus digits");
    wr_coef(3, 20'b00_00_00_00_00_00_00_01_00_11, e1, e2);
    check("R8", e1, 0, "coef_err for legal digits");
    cur_req = "R3";
    impulse(7);
    flush();

    // R7: out-of-range tap index
    wr_coef(18, csd_encode(341), e1, e2);
    wr_coef(31, csd_encode(-200), e1, e2);
    cur_req = "R7";
    impulse(9);
    flush();

    // R6: write in the same cycle as a sample applies afterwards
    cur_req = "R6";
    put_sample_wr(4, 0, csd_encode(-100));
    put_sample(4);
    put_sample(0);
    wr_coef(2, csd_encode(50), e1, e2);
    repeat (3) @(negedge clk);
    put_sample(3);
    put_sample(0);
    put_sample(0);
    flush();

    // R10: result holds between valid outputs
    held = int'(out_sample);
    repeat (5) @(negedge clk);
    check("R10", int'(out_sample), held, "out_sample held");
    check("R10", out_valid, 0, "out_valid idle");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule